// File: doc/BRIEF.md
# Unprivileged word load aligner

This block sits in the load path of a 32-bit core. It handles word loads that must run with user-level rights even while the core is in a privileged mode. A request carries the byte address, the core's current mode, an alignment-check enable, and base and destination register indices. The request is qualified by a single pass flag from upstream condition evaluation. The block issues one memory read at the word-aligned address, always tagged unprivileged, and accepts the returned word. It then either writes back the word rotated right by whole bytes according to the low address bits, or reports a fault.

The request side and both memory channels use valid/ready handshakes. Only one read is outstanding at a time. A misaligned request with checking enabled is rejected at acceptance with no bus traffic. A data abort from memory is passed on in the same cycle as the response, in place of the write-back.

Top module: `uwl_aligner`

## Requirements
- R1: After reset, req_ready is 1 and mem_rd_valid, mem_rsp_ready, wb_valid, align_fault, abort_out and overlap_flag are all 0.
- R2: mem_rd_addr equals the request byte address with bits 1:0 forced to 00.
- R3: mem_rd_user is 1 on every read. A core in a privileged mode (req_priv=1) and a core in user mode (req_priv=0) give the same bus request and the same write-back.
- R4: The write-back word is the returned word rotated right by 0, 8, 16 or 24 bits for address bits 1:0 of 00, 01, 10 or 11.
- R5: With req_align_chk=1 and address bits 1:0 not 00, align_fault is 1 in the acceptance cycle and no read or write-back follows. With req_align_chk=0, a misaligned address loads normally.
- R6: A request accepted with req_pass=0 causes no read, no write-back, no align_fault and no overlap_flag.
- R7: overlap_flag is 1 in the acceptance cycle of a passing request whose req_dest equals req_base, and the load still completes.
- R8: req_ready is 1 only while idle. mem_rd_valid holds with a stable address until mem_rd_ready. mem_rsp_ready is 1 only after the read is taken.
- R9: A response with mem_rsp_abort=1 gives abort_out=1 in that same cycle and wb_valid=0.
- R10: A good response gives wb_valid=1 for exactly that cycle, with wb_reg equal to the request's req_dest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Byte address |
| req_pass | input | 1 | Condition passed; 0 drops the request |
| req_priv | input | 1 | 1 = core privileged, 0 = core in user mode |
| req_align_chk | input | 1 | Alignment checking enabled |
| req_base | input | 4 | Base register index |
| req_dest | input | 4 | Destination register index |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_user | output | 1 | Access tag, 1 = unprivileged |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_ready | output | 1 | Block waits for a response |
| mem_rsp_data | input | 32 | Returned word |
| mem_rsp_abort | input | 1 | Memory reports a data abort |
| wb_valid | output | 1 | Write-back strobe |
| wb_reg | output | 4 | Write-back register index |
| wb_data | output | 32 | Rotated load result |
| align_fault | output | 1 | Alignment fault pulse |
| abort_out | output | 1 | Forwarded data abort pulse |
| overlap_flag | output | 1 | Destination equals base (unpredictable result) |

## Verification
The bench drives all four byte offsets with a word whose bytes all differ. A rotation in the wrong direction or by the wrong amount therefore shows up as a wrong wb_data. The same offsets are run with checking off and on: a design that ignores the enable either faults on loads it should perform or reads memory on loads it should reject. The bench also holds mem_rd_ready low, injects an abort, drops a request whose pass flag is low, and issues a request with the destination equal to the base. A design that gets these wrong lets the address drift, writes back aborted data, touches the bus for a dropped request, or misses the overlap flag. Privileged and user-mode requests are compared so that a tag following the core mode is caught.

// File: rtl/uwl_pkg.sv
package uwl_pkg;
   typedef enum logic [1:0] {
      UWL_IDLE  = 2'd0,
      UWL_ISSUE = 2'd1,
      UWL_WAIT  = 2'd2
   } uwl_state_e;
endpackage

// File: rtl/uwl_screen.sv
// Classifies a request at the handshake: drop, fault, or start a read.
module uwl_screen #(
   parameter int RW = 4,
   parameter int LB = 2
) (
   input  logic          req_valid,
   input  logic          req_ready,
   input  logic          req_pass,
   input  logic          req_align_chk,
   input  logic [LB-1:0] addr_lo,
   input  logic [RW-1:0] req_base,
   input  logic [RW-1:0] req_dest,
   output logic          start,
   output logic          fault,
   output logic          overlap
);
   logic accept;
   logic live;
   logic misaligned;

   assign accept     = req_valid & req_ready;
   assign live       = accept & req_pass;
   assign misaligned = |addr_lo;
   assign fault      = live & req_align_chk & misaligned;
   assign overlap    = live & (req_base == req_dest);
   assign start      = live & ~fault;
endmodule

// File: rtl/uwl_ctrl.sv
// One-outstanding read sequencer with captured request fields.
module uwl_ctrl
   import uwl_pkg::*;
#(
   parameter int AW = 32,
   parameter int RW = 4,
   parameter int LB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] addr,
   input  logic [RW-1:0] dest,
   input  logic          mem_rd_ready,
   input  logic          mem_rsp_valid,
   output logic          req_ready,
   output logic          mem_rd_valid,
   output logic [AW-1:0] mem_rd_addr,
   output logic          mem_rsp_ready,
   output logic          rsp_fire,
   output logic [RW-1:0] dest_q,
   output logic [LB-1:0] rot_q
);
   uwl_state_e       state;
   logic [AW-LB-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= UWL_IDLE;
         word_q <= '0;
         rot_q  <= '0;
         dest_q <= '0;
      end else begin
         case (state)
            UWL_IDLE: if (start) begin
               state  <= UWL_ISSUE;
               word_q <= addr[AW-1:LB];
               rot_q  <= addr[LB-1:0];
               dest_q <= dest;
            end
            UWL_ISSUE: if (mem_rd_ready) state <= UWL_WAIT;
            UWL_WAIT:  if (mem_rsp_valid) state <= UWL_IDLE;
            default:   state <= UWL_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == UWL_IDLE);
   assign mem_rd_valid  = (state == UWL_ISSUE);
   assign mem_rd_addr   = {word_q, {LB{1'b0}}};
   assign mem_rsp_ready = (state == UWL_WAIT);
   assign rsp_fire      = mem_rsp_ready & mem_rsp_valid;
endmodule

// File: rtl/uwl_rotate.sv
// Byte-granular right rotation; IMPL picks the structure.
module uwl_rotate #(
   parameter int DW   = 32,
   parameter int LB   = 2,
   parameter int IMPL = 0
) (
   input  logic [DW-1:0] din,
   input  logic [LB-1:0] lanes,
   output logic [DW-1:0] dout
);
   localparam int LANES = DW / 8;

   generate
      if (IMPL == 0) begin : g_shift
         logic [2*DW-1:0] dbl;
         assign dbl  = {din, din} >> {lanes, 3'b000};
         assign dout = dbl[DW-1:0];
      end else begin : g_mux
         logic [DW-1:0] cand [LANES];
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            if (k == 0) begin : g_zero
               assign cand[k] = din;
            end else begin : g_rot
               assign cand[k] = {din[8*k-1:0], din[DW-1:8*k]};
            end
         end
         assign dout = cand[lanes];
      end
   endgenerate
endmodule

// File: rtl/uwl_aligner.sv
module uwl_aligner #(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int RW       = 4,
   parameter int ROT_IMPL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic          req_pass,
   input  logic          req_priv,
   input  logic          req_align_chk,
   input  logic [RW-1:0] req_base,
   input  logic [RW-1:0] req_dest,
   output logic          mem_rd_valid,
   input  logic          mem_rd_ready,
   output logic [AW-1:0] mem_rd_addr,
   output logic          mem_rd_user,
   input  logic          mem_rsp_valid,
   output logic          mem_rsp_ready,
   input  logic [DW-1:0] mem_rsp_data,
   input  logic          mem_rsp_abort,
   output logic          wb_valid,
   output logic [RW-1:0] wb_reg,
   output logic [DW-1:0] wb_data,
   output logic          align_fault,
   output logic          abort_out,
   output logic          overlap_flag
);
   localparam int LANES = DW / 8;
   localparam int LB    = $clog2(LANES);

   generate
      if ((DW % 8) != 0 || LANES < 2 || (1 << LB) != LANES) begin : g_bad_dw
         $error("uwl_aligner: DW must be a power-of-two count of bytes, at least 2");
      end
      if (AW <= LB) begin : g_bad_aw
         $error("uwl_aligner: AW too narrow for the byte offset");
      end
      if (RW < 1) begin : g_bad_rw
         $error("uwl_aligner: RW must be at least 1");
      end
      if (ROT_IMPL != 0 && ROT_IMPL != 1) begin : g_bad_impl
         $error("uwl_aligner: ROT_IMPL must be 0 or 1");
      end
   endgenerate

   logic          start;
   logic          rsp_fire;
   logic [RW-1:0] dest_q;
   logic [LB-1:0] rot_q;
   logic [DW-1:0] rotated;

   uwl_screen #(.RW(RW), .LB(LB)) i_screen (
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_pass      (req_pass),
      .req_align_chk (req_align_chk),
      .addr_lo       (req_addr[LB-1:0]),
      .req_base      (req_base),
      .req_dest      (req_dest),
      .start         (start),
      .fault         (align_fault),
      .overlap       (overlap_flag)
   );

   uwl_ctrl #(.AW(AW), .RW(RW), .LB(LB)) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .addr          (req_addr),
      .dest          (req_dest),
      .mem_rd_ready  (mem_rd_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .req_ready     (req_ready),
      .mem_rd_valid  (mem_rd_valid),
      .mem_rd_addr   (mem_rd_addr),
      .mem_rsp_ready (mem_rsp_ready),
      .rsp_fire      (rsp_fire),
      .dest_q        (dest_q),
      .rot_q         (rot_q)
   );

   uwl_rotate #(.DW(DW), .LB(LB), .IMPL(ROT_IMPL)) i_rotate (
      .din   (mem_rsp_data),
      .lanes (rot_q),
      .dout  (rotated)
   );

   // The bus tag ignores the core mode: every access is unprivileged.
   assign mem_rd_user = 1'b1;
   assign wb_valid    = rsp_fire & ~mem_rsp_abort;
   assign abort_out   = rsp_fire & mem_rsp_abort;
   assign wb_reg      = dest_q;
   assign wb_data     = rotated;
endmodule

// File: rtl/uwl_checker.sv
module uwl_checker #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_pass,
   input logic          req_priv,
   input logic          mem_rd_valid,
   input logic          mem_rd_ready,
   input logic [AW-1:0] mem_rd_addr,
   input logic          mem_rd_user,
   input logic          mem_rsp_ready,
   input logic          wb_valid,
   input logic          align_fault,
   input logic          abort_out,
   input logic          overlap_flag
);
   assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

   assert_priv_tagged_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_pass && req_priv && !align_fault)
      |=> (mem_rd_valid && mem_rd_user));

   assert_fault_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |=> (!mem_rd_valid && req_ready));

   assert_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_pass)
      |-> (!align_fault && !overlap_flag) ##1 !mem_rd_valid);

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid || mem_rsp_ready) |-> !req_ready);

   assert_abort_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort_out |-> !wb_valid);

   assert_wb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid);
endmodule

bind uwl_aligner uwl_checker #(.AW(AW)) i_uwl_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_pass      (req_pass),
   .req_priv      (req_priv),
   .mem_rd_valid  (mem_rd_valid),
   .mem_rd_ready  (mem_rd_ready),
   .mem_rd_addr   (mem_rd_addr),
   .mem_rd_user   (mem_rd_user),
   .mem_rsp_ready (mem_rsp_ready),
   .wb_valid      (wb_valid),
   .align_fault   (align_fault),
   .abort_out     (abort_out),
   .overlap_flag  (overlap_flag)
);

// File: tb/test_uwl_aligner.sv
`timescale 1ns/1ps
module test_uwl_aligner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_ready;
   logic [31:0] req_addr = '0;
   logic        req_pass = 1'b0, req_priv = 1'b0, req_align_chk = 1'b0;
   logic [3:0]  req_base = '0, req_dest = '0;
   logic        mem_rd_valid, mem_rd_ready = 1'b0, mem_rd_user;
   logic [31:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0, mem_rsp_ready, mem_rsp_abort = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        wb_valid, align_fault, abort_out, overlap_flag;
   logic [3:0]  wb_reg;
   logic [31:0] wb_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   uwl_aligner i_uwl_aligner (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] byte_ror(input logic [31:0] d, input int n);
      logic [31:0] r = d;
      for (int i = 0; i < n; i++) r = {r[7:0], r[31:8]};
      return r;
   endfunction

   task automatic run_load(input logic [31:0] addr, input logic priv, input logic chk,
                           input logic pass, input logic [3:0] base, input logic [3:0] dest,
                           input logic [31:0] data, input logic abrt);
      logic mis, exp_fault, exp_ovl, go;
      mis       = (addr[1:0] != 2'b00);
      exp_fault = pass && chk && mis;
      exp_ovl   = pass && (base == dest);
      go        = pass && !exp_fault;
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_priv = priv; req_align_chk = chk;
      req_pass = pass; req_base = base; req_dest = dest;
      #1;
      check("R8 ready when idle", req_ready, 1);
      check("R5 fault at accept", align_fault, exp_fault);
      check("R7 overlap at accept", overlap_flag, exp_ovl);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      if (!go) begin
         check("R6/R5 no read", mem_rd_valid, 0);
         check("R6/R5 still ready", req_ready, 1);
         check("R6/R5 no wb", wb_valid, 0);
         return;
      end
      check("R8 read issued", mem_rd_valid, 1);
      check("R2 word address", mem_rd_addr, {addr[31:2], 2'b00});
      check("R3 user tag", mem_rd_user, 1);
      check("R8 busy", req_ready, 0);
      @(posedge clk);
      @(negedge clk);
      check("R8 read held", mem_rd_valid, 1);
      check("R8 address stable", mem_rd_addr, {addr[31:2], 2'b00});
      mem_rd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_rd_ready = 1'b0;
      #1;
      check("R8 read taken", mem_rd_valid, 0);
      check("R8 rsp ready", mem_rsp_ready, 1);
      check("R10 no early wb", wb_valid, 0);
      mem_rsp_valid = 1'b1; mem_rsp_data = data; mem_rsp_abort = abrt;
      #1;
      check("R9 abort out", abort_out, abrt);
      check("R10 wb strobe", wb_valid, !abrt);
      if (!abrt) begin
         check("R4 rotated data", wb_data, byte_ror(data, int'(addr[1:0])));
         check("R10 wb reg", wb_reg, dest);
      end
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_abort = 1'b0;
      #1;
      check("R10 single pulse", wb_valid, 0);
      check("R9 abort single", abort_out, 0);
      check("R8 idle again", req_ready, 1);
   endtask

   task automatic t_reset;
      #1;
      check("R1 req_ready", req_ready, 1);
      check("R1 mem_rd_valid", mem_rd_valid, 0);
      check("R1 mem_rsp_ready", mem_rsp_ready, 0);
      check("R1 wb_valid", wb_valid, 0);
      check("R1 align_fault", align_fault, 0);
      check("R1 abort_out", abort_out, 0);
      check("R1 overlap_flag", overlap_flag, 0);
   endtask

   task automatic t_rotations; // R4, R2, R3, checking off
      for (int k = 0; k < 4; k++)
         run_load(32'h1000_0040 + k, 1'b1, 1'b0, 1'b1, 4'd2, 4'd5, 32'hA1B2_C3D4, 1'b0);
   endtask

   task automatic t_user_mode; // R3
      for (int k = 0; k < 4; k++)
         run_load(32'h2000_0010 + k, 1'b0, 1'b0, 1'b1, 4'd1, 4'd9, 32'h0123_4567, 1'b0);
   endtask

   task automatic t_align_fault; // R5
      for (int k = 1; k < 4; k++)
         run_load(32'h3000_0000 + k, 1'b1, 1'b1, 1'b1, 4'd3, 4'd4, 32'hDEAD_BEEF, 1'b0);
      run_load(32'h3000_0008, 1'b1, 1'b1, 1'b1, 4'd3, 4'd4, 32'hCAFE_F00D, 1'b0);
   endtask

   task automatic t_no_pass; // R6
      run_load(32'h4000_0003, 1'b1, 1'b1, 1'b0, 4'd6, 4'd6, 32'h1111_2222, 1'b0);
      run_load(32'h4000_0000, 1'b1, 1'b0, 1'b0, 4'd6, 4'd7, 32'h1111_2222, 1'b0);
   endtask

   task automatic t_overlap; // R7
      run_load(32'h5000_0002, 1'b1, 1'b0, 1'b1, 4'd8, 4'd8, 32'h8899_AABB, 1'b0);
   endtask

   task automatic t_abort; // R9
      run_load(32'h6000_0001, 1'b1, 1'b0, 1'b1, 4'd0, 4'd12, 32'h5555_AAAA, 1'b1);
      run_load(32'h6000_0003, 1'b0, 1'b0, 1'b1, 4'd0, 4'd13, 32'h7766_5544, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rotations();
      t_user_mode();
      t_align_fault();
      t_no_pass();
      t_overlap();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule